// File: doc/BRIEF.md
# Scrolled Tilemap Layer Pixel Fetcher

This block turns a raster position into a palette index for one scrolled tilemap layer. The layer is a 64 by 64 grid of 8 by 8 pixel tiles, so it covers a 512 by 512 pixel plane. The plane is shown through a 496 by 384 window, and each axis wraps on its own. For every accepted pixel the block applies the vertical scroll. It takes the horizontal scroll either from the layer's control word or from a per-line table in video memory. It then reads the tile's name entry and the matching pattern row, and forms a 15-bit palette index in either 4-bit or 8-bit colour mode.

The block has four stages. The first three each issue one read on a dedicated synchronous 32-bit port of the video memory: the line-scroll table, the name table and the pattern data. Each port returns its data one cycle after the address. A new pixel can enter on every cycle. The palette lookup and the mixing of layers are done downstream.

Top module: `tile_layer_fetch`

## Requirements
- R1: A pixel accepted with `px_valid_i` high at clock edge k produces `pal_valid_o` high after edge k+4. Edges with no accepted pixel produce `pal_valid_o` low four edges later.
- R2: The map row is `(px_y_i + scroll_i[24:16]) mod 512`. Rows wrap from the bottom of the map back to the top.
- R3: When `scroll_i[15]` is 0, the map column is `(px_x_i + scroll_i[9:0]) mod 512`. Columns wrap within the same row.
- R4: When `scroll_i[15]` is 1, the horizontal scroll is a 16-bit entry read at word address `(0xF6000 + LAYER*0x400 + 2*px_y_i)/4`. An even raster line takes bits 31:16 of that word and an odd line takes bits 15:0. The control word's own horizontal field is then ignored.
- R5: The name entry for tile (row, col) is read at word address `(0xF8000 + LAYER*0x2000 + 2*(64*row + col))/4`. An even column takes bits 31:16 of the word and an odd column takes bits 15:0.
- R6: With `depth4_i` = 1, an entry e reads the pattern word at `{e[13:4], e[3:0], e[15]}*8 + (row mod 8)`. The pixel is nibble `x mod 8` counted from bits 31:28, and the index is `{e[14], e[13:4], nibble}`.
- R7: With `depth4_i` = 0, the pattern word is read at `(e[14:0]*16 + (row mod 8)*2 + bit 2 of the fine x) mod 2^18`. The pixel is byte `x mod 4` counted from bits 31:24, and the index is `{e[14:8], byte}`.
- R8: When `scroll_i[31]` is 0, the pixel still leaves with `pal_valid_o` high and the same latency, but with `transparent_o` high and `pal_idx_o` zero. When `scroll_i[31]` is 1, `transparent_o` is low.
- R9: While `pal_valid_o` is low, `pal_idx_o` and `transparent_o` keep the values of the last output pixel.
- R10: Reset drives `pal_valid_o`, `transparent_o` and `pal_idx_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| px_valid_i | input | 1 | Raster position is valid this cycle |
| px_x_i | input | 9 | Raster column |
| px_y_i | input | 9 | Raster line |
| scroll_i | input | 32 | Layer control word: enable, vertical scroll, line-scroll select, horizontal scroll |
| depth4_i | input | 1 | 1 selects 4-bit colour, 0 selects 8-bit colour |
| tbl_addr_o | output | 18 | Word address on the line-scroll table port |
| tbl_data_i | input | 32 | Read data for `tbl_addr_o`, one cycle later |
| name_addr_o | output | 18 | Word address on the name table port |
| name_data_i | input | 32 | Read data for `name_addr_o`, one cycle later |
| pat_addr_o | output | 18 | Word address on the pattern port |
| pat_data_i | input | 32 | Read data for `pat_addr_o`, one cycle later |
| pal_valid_o | output | 1 | Output pixel strobe |
| pal_idx_o | output | 15 | Palette index |
| transparent_o | output | 1 | Pixel comes from a disabled layer |

## Verification
The hardest case to reach is the combination of a per-line table scroll with wrap-around. In that case an odd raster line must pick the low half of the table word, and the scrolled column then crosses from the last tile of the row back to tile 0, which flips the name-entry half. The stimulus reaches it by sweeping several lines and columns with line scroll on. It also runs a full sweep past column 511 with a large register scroll.

The video memory model fills every word with a hash of its address. This yields large 15-bit pattern indices, so the 8-bit mode address wraps past the top of memory. It also means that a wrong address at any stage shows up as a wrong palette index.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
  localparam int COORD_W = 9;
  localparam int FINE_W  = 3;
  localparam int TILE_W  = COORD_W - FINE_W;
  localparam int ADDR_W  = 18;
  localparam int DATA_W  = 32;
  localparam int PAL_W   = 15;
  localparam int PHI_W   = 11;
  localparam int PIX4    = 1 << FINE_W;
  localparam int PIX8    = PIX4 / 2;

  // word-address bases of per-layer regions
  localparam logic [ADDR_W-1:0] TBL_WBASE  = 18'h3D800;
  localparam int                TBL_WSTEP  = 256;
  localparam logic [ADDR_W-1:0] NAME_WBASE = 18'h3E000;
  localparam int                NAME_WSTEP = 2048;

  // control word fields
  localparam int SC_EN   = 31;
  localparam int SC_VS   = 16;
  localparam int SC_LSEL = 15;

  typedef struct packed {
    logic               vld;
    logic               en;
    logic               d4;
    logic               lsel;
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] ly;
    logic [COORD_W-1:0] yw;
    logic [COORD_W-1:0] hs;
  } line_t;

  typedef struct packed {
    logic              vld;
    logic              en;
    logic              d4;
    logic              odd_col;
    logic [FINE_W-1:0] xf;
    logic [FINE_W-1:0] yf;
  } name_t;

  typedef struct packed {
    logic              vld;
    logic              en;
    logic              d4;
    logic [FINE_W-1:0] xf;
    logic [PHI_W-1:0]  phi;
  } pat_t;
endpackage

// File: rtl/tlf_line_stage.sv
module tlf_line_stage
  import tlf_pkg::*;
#(
  parameter int LAYER = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                px_valid_i,
  input  logic [COORD_W-1:0]  px_x_i,
  input  logic [COORD_W-1:0]  px_y_i,
  input  logic [DATA_W-1:0]   scroll_i,
  input  logic                depth4_i,
  output line_t               line_o,
  output logic [ADDR_W-1:0]   tbl_addr_o
);
  localparam logic [ADDR_W-1:0] TBL_LBASE = TBL_WBASE + ADDR_W'(LAYER * TBL_WSTEP);

  line_t r0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r0 <= '0;
    end else begin
      r0.vld  <= px_valid_i;
      r0.en   <= scroll_i[SC_EN];
      r0.d4   <= depth4_i;
      r0.lsel <= scroll_i[SC_LSEL];
      r0.x    <= px_x_i;
      r0.ly   <= px_y_i;
      r0.yw   <= px_y_i + scroll_i[SC_VS +: COORD_W];
      r0.hs   <= scroll_i[COORD_W-1:0];
    end
  end

  // two 16-bit line entries per word
  assign tbl_addr_o = TBL_LBASE + ADDR_W'(r0.ly[COORD_W-1:1]);
  assign line_o     = r0;
endmodule

// File: rtl/tlf_name_stage.sv
module tlf_name_stage
  import tlf_pkg::*;
#(
  parameter int LAYER = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  line_t              line_i,
  input  logic [DATA_W-1:0]  tbl_data_i,
  output name_t              name_o,
  output logic [ADDR_W-1:0]  name_addr_o
);
  localparam logic [ADDR_W-1:0] NAME_LBASE = NAME_WBASE + ADDR_W'(LAYER * NAME_WSTEP);

  line_t              r1;
  logic [COORD_W-1:0] hs_eff;
  logic [COORD_W-1:0] xw;
  logic [TILE_W-1:0]  col, row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r1 <= '0;
    else         r1 <= line_i;
  end

  // even line in upper half, odd line in lower half
  always_comb begin
    if (!r1.lsel)     hs_eff = r1.hs;
    else if (r1.ly[0]) hs_eff = tbl_data_i[COORD_W-1:0];
    else              hs_eff = tbl_data_i[16 +: COORD_W];
  end

  assign xw  = r1.x + hs_eff;
  assign col = xw[COORD_W-1:FINE_W];
  assign row = r1.yw[COORD_W-1:FINE_W];

  assign name_addr_o = NAME_LBASE + ADDR_W'({row, col[TILE_W-1:1]});

  assign name_o.vld     = r1.vld;
  assign name_o.en      = r1.en;
  assign name_o.d4      = r1.d4;
  assign name_o.odd_col = col[0];
  assign name_o.xf      = xw[FINE_W-1:0];
  assign name_o.yf      = r1.yw[FINE_W-1:0];
endmodule

// File: rtl/tlf_pat_stage.sv
module tlf_pat_stage
  import tlf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  name_t              name_i,
  input  logic [DATA_W-1:0]  name_data_i,
  output pat_t               pat_o,
  output logic [ADDR_W-1:0]  pat_addr_o
);
  name_t            r2;
  logic [15:0]      ent;
  logic [14:0]      idx4, idx8;
  logic [ADDR_W-1:0] a4;
  logic [ADDR_W:0]   a8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r2 <= '0;
    else         r2 <= name_i;
  end

  // left tile in upper half
  assign ent = r2.odd_col ? name_data_i[15:0] : name_data_i[31:16];

  // 4-bit: entry MSB becomes the index LSB
  assign idx4 = {ent[13:4], ent[3:0], ent[15]};
  assign idx8 = ent[14:0];
  assign a4   = {idx4, r2.yf};
  assign a8   = {idx8, r2.yf, r2.xf[FINE_W-1]};

  assign pat_addr_o = r2.d4 ? a4 : a8[ADDR_W-1:0];

  assign pat_o.vld = r2.vld;
  assign pat_o.en  = r2.en;
  assign pat_o.d4  = r2.d4;
  assign pat_o.xf  = r2.xf;
  assign pat_o.phi = r2.d4 ? {ent[14], ent[13:4]} : {4'b0, ent[14:8]};
endmodule

// File: rtl/tlf_pix_stage.sv
module tlf_pix_stage
  import tlf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  pat_t               pat_i,
  input  logic [DATA_W-1:0]  pat_data_i,
  output logic               pal_valid_o,
  output logic [PAL_W-1:0]   pal_idx_o,
  output logic               transparent_o
);
  pat_t             r3;
  logic [3:0]       nib [PIX4];
  logic [7:0]       byt [PIX8];
  logic [PAL_W-1:0] idx_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r3 <= '0;
    else         r3 <= pat_i;
  end

  // leftmost pixel in the top bits
  for (genvar g = 0; g < PIX4; g++) begin : g_nib
    assign nib[g] = pat_data_i[DATA_W-1-4*g -: 4];
  end
  for (genvar g = 0; g < PIX8; g++) begin : g_byt
    assign byt[g] = pat_data_i[DATA_W-1-8*g -: 8];
  end

  assign idx_c = r3.d4 ? {r3.phi, nib[r3.xf]}
                       : {r3.phi[6:0], byt[r3.xf[FINE_W-2:0]]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pal_valid_o   <= 1'b0;
      pal_idx_o     <= '0;
      transparent_o <= 1'b0;
    end else begin
      pal_valid_o <= r3.vld;
      if (r3.vld) begin
        transparent_o <= ~r3.en;
        pal_idx_o     <= r3.en ? idx_c : '0;
      end
    end
  end
endmodule

// File: rtl/tile_layer_fetch.sv
module tile_layer_fetch
  import tlf_pkg::*;
#(
  parameter int LAYER = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                px_valid_i,
  input  logic [COORD_W-1:0]  px_x_i,
  input  logic [COORD_W-1:0]  px_y_i,
  input  logic [DATA_W-1:0]   scroll_i,
  input  logic                depth4_i,
  output logic [ADDR_W-1:0]   tbl_addr_o,
  input  logic [DATA_W-1:0]   tbl_data_i,
  output logic [ADDR_W-1:0]   name_addr_o,
  input  logic [DATA_W-1:0]   name_data_i,
  output logic [ADDR_W-1:0]   pat_addr_o,
  input  logic [DATA_W-1:0]   pat_data_i,
  output logic                pal_valid_o,
  output logic [PAL_W-1:0]    pal_idx_o,
  output logic                transparent_o
);
  line_t line_s;
  name_t name_s;
  pat_t  pat_s;

  tlf_line_stage #(.LAYER(LAYER)) u_line (
    .clk_i, .rst_ni, .px_valid_i, .px_x_i, .px_y_i, .scroll_i, .depth4_i,
    .line_o(line_s), .tbl_addr_o
  );

  tlf_name_stage #(.LAYER(LAYER)) u_name (
    .clk_i, .rst_ni, .line_i(line_s), .tbl_data_i,
    .name_o(name_s), .name_addr_o
  );

  tlf_pat_stage u_pat (
    .clk_i, .rst_ni, .name_i(name_s), .name_data_i,
    .pat_o(pat_s), .pat_addr_o
  );

  tlf_pix_stage u_pix (
    .clk_i, .rst_ni, .pat_i(pat_s), .pat_data_i,
    .pal_valid_o, .pal_idx_o, .transparent_o
  );

  // cycles since reset, saturating at the checked history depth
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 3'd5) age_q <= age_q + 3'd1;
  end

  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd5) |-> (pal_valid_o == $past(px_valid_i, 5)));

  // R8
  transp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd5 && pal_valid_o) |-> (transparent_o == !$past(scroll_i[SC_EN], 5)));

  // R8
  transp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pal_valid_o && transparent_o) |-> (pal_idx_o == '0));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 3'd0 && !pal_valid_o) |-> ($stable(pal_idx_o) && $stable(transparent_o)));
endmodule

// File: tb/tb_tile_layer_fetch.sv
module tb_tile_layer_fetch;
  localparam int LAYER = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        px_valid = 1'b0;
  logic [8:0]  px_x = '0, px_y = '0;
  logic [31:0] scroll = '0;
  logic        depth4 = 1'b0;
  logic [17:0] tbl_addr, name_addr, pat_addr;
  logic [31:0] tbl_data, name_data, pat_data;
  logic        pal_valid, transparent;
  logic [14:0] pal_idx;

  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  tile_layer_fetch #(.LAYER(LAYER)) dut (
    .clk_i(clk), .rst_ni(rst_n), .px_valid_i(px_valid), .px_x_i(px_x), .px_y_i(px_y),
    .scroll_i(scroll), .depth4_i(depth4),
    .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data),
    .name_addr_o(name_addr), .name_data_i(name_data),
    .pat_addr_o(pat_addr), .pat_data_i(pat_data),
    .pal_valid_o(pal_valid), .pal_idx_o(pal_idx), .transparent_o(transparent)
  );

  function automatic logic [31:0] vf(input logic [17:0] a);
    logic [31:0] t;
    t = {14'b0, a} * 32'h9E3779B1;
    return t ^ (t >> 13) ^ {a[7:0], a, 6'h15};
  endfunction

  // synchronous read ports
  always_ff @(posedge clk) begin
    tbl_data  <= vf(tbl_addr);
    name_data <= vf(name_addr);
    pat_data  <= vf(pat_addr);
  end

  function automatic void model(input int x, input int y, input logic [31:0] sc,
                                input bit d4, output bit tr, output int idx);
    int yw, hs, xw, col, row, pi;
    logic [31:0] w, pw;
    logic [15:0] e;
    if (!sc[31]) begin tr = 1; idx = 0; return; end
    tr = 0;
    yw = (y + int'(sc[24:16])) % 512;
    if (sc[15]) begin
      w  = vf(18'((32'hF6000 + LAYER*1024 + y*2) >> 2));
      hs = (y % 2 == 1) ? int'(w[15:0]) : int'(w[31:16]);
    end else hs = int'(sc[9:0]);
    xw  = (x + hs) % 512;
    col = xw / 8;
    row = yw / 8;
    w = vf(18'((32'hF8000 + LAYER*8192 + (row*64 + col)*2) >> 2));
    e = (col % 2 == 1) ? w[15:0] : w[31:16];
    if (d4) begin
      pi  = (int'(e[13:4]) << 5) | (int'(e[3:0]) << 1) | int'(e[15]);
      pw  = vf(18'((pi*32 + (yw % 8)*4) >> 2));
      idx = (int'(e[14]) << 14) | (int'(e[13:4]) << 4) | int'((pw >> (28 - 4*(xw % 8))) & 32'hF);
    end else begin
      pi  = int'(e[14:0]);
      pw  = vf(18'(((pi*64 + (yw % 8)*8 + (((xw % 8) >= 4) ? 4 : 0)) >> 2) % 262144));
      idx = (int'(e[14:8]) << 8) | int'((pw >> (24 - 8*(xw % 4))) & 32'hFF);
    end
  endfunction

  typedef struct {
    bit    vld;
    bit    tr;
    int    idx;
    string tag;
  } exp_t;

  exp_t q[$];
  bit   last_tr  = 0;
  int   last_idx = 0;

  task automatic step(input bit v, input int x, input int y, input logic [31:0] sc,
                      input bit d4, input string tag);
    exp_t e, o;
    bit tr;
    int idx;
    @(negedge clk);
    if (q.size() == 5) begin
      o = q.pop_front();
      checks++;
      if (pal_valid !== o.vld || transparent !== o.tr || pal_idx !== 15'(o.idx)) begin
        errors++;
        $display("FAIL %s: valid/transp/idx %0b/%0b/%h expected %0b/%0b/%h",
                 o.tag, pal_valid, transparent, pal_idx, o.vld, o.tr, 15'(o.idx));
      end
    end
    px_valid = v; px_x = 9'(x); px_y = 9'(y); scroll = sc; depth4 = d4;
    if (v) begin
      model(x, y, sc, d4, tr, idx);
      e.vld = 1; e.tr = tr; e.idx = idx;
      last_tr = tr; last_idx = idx;
    end else begin
      e.vld = 0; e.tr = last_tr; e.idx = last_idx;
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic [31:0] sw(input bit en, input int vs, input bit ls, input int hs);
    return {en, 6'b0, 9'(vs), ls, 5'b0, 10'(hs)};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1: watchdog expired, run incomplete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R10 reset state
    repeat (3) @(negedge clk);
    checks++;
    if (pal_valid !== 1'b0 || transparent !== 1'b0 || pal_idx !== '0) begin
      errors++;
      $display("FAIL R10: valid/transp/idx %0b/%0b/%h expected 0/0/0000", pal_valid, transparent, pal_idx);
    end
    rst_n = 1'b1;

    // R3 register scroll, x wraps within the line
    for (int x = 0; x < 512; x++) step(1, x, 10, sw(1, 0, 0, 10'h3F0), 1, "R3");
    // R2 vertical wrap
    for (int y = 0; y < 512; y++) step(1, y % 64, y, sw(1, 9'h1C0, 0, 0), 1, "R2");
    // R4 line scroll, register field ignored
    for (int y = 0; y < 64; y++)
      for (int k = 0; k < 4; k++) step(1, k*160 + 15, y, sw(1, 7, 1, 10'h155), (y % 3) != 0, "R4");
    // R5 column parity selects name-entry half
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 64; x++) step(1, x, y*9, sw(1, 0, 0, 3), 1, "R5");
    // R6 4-bit mode
    for (int i = 0; i < 300; i++)
      step(1, $urandom % 496, $urandom % 384, sw(1, $urandom % 512, $urandom % 2, $urandom % 1024), 1, "R6");
    // R7 8-bit mode
    for (int i = 0; i < 400; i++)
      step(1, $urandom % 496, $urandom % 384, sw(1, $urandom % 512, $urandom % 2, $urandom % 1024), 0, "R7");
    // R8 disabled layer keeps timing
    for (int i = 0; i < 300; i++)
      step(1, $urandom % 496, $urandom % 384, sw($urandom % 2, $urandom % 512, $urandom % 2, $urandom % 1024),
           $urandom % 2, "R8");
    // R1 latency with gaps, R9 hold during gaps
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 2)
        step(1, $urandom % 496, $urandom % 384, sw($urandom % 4 != 0, $urandom % 512, $urandom % 2, $urandom % 1024),
             $urandom % 2, "R1");
      else
        step(0, $urandom % 512, $urandom % 512, $urandom, $urandom % 2, "R9");
    end
    for (int i = 0; i < 6; i++) step(0, 0, 0, '0, 0, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule